// File: doc/BRIEF.md
# Retrying IN Endpoint Transmit Buffer

This block holds the payload of one non-isochronous USB device IN endpoint on its way from the processor to the host. The processor loads bytes into it one at a time and then sets an enable flag to offer the packet. When the serializer sees an IN token for the endpoint, the buffer either answers NAK (nothing offered) or starts a data phase and hands out its bytes in load order, one per read request.

The stored packet is released only when the host acknowledges it. A handshake timeout or a corrupted token leaves every byte, the byte count and the enable flag untouched, so the next IN token replays the same packet from its first byte. A successful acknowledge empties the buffer, clears the enable flag and raises a one-cycle completion interrupt. If the processor flushes the buffer while a data phase is in progress, the block tells the serializer to corrupt the packet on the wire with a forced bit-stuff error, so the host discards it.

Top module: `in_ep_txbuf`

## Requirements
- R1: While the enable flag is clear, each cycle with `cpu_wr_en` high stores `cpu_wr_data` at index `cpu_byte_count` and increments the count. Once the count equals DEPTH, further writes are dropped and the count stays at DEPTH.
- R2: While the enable flag is set, writes are ignored and the byte count does not change.
- R3: An error-free IN token that arrives while the enable flag is clear produces a one-cycle `sie_send_nak` pulse in the next cycle and no `sie_send_data` pulse.
- R4: An error-free IN token that arrives while the enable flag is set and no data phase is open produces a one-cycle `sie_send_data` pulse in the next cycle. Each `sie_rd_req` then consumes one byte: `sie_rd_data` shows the bytes in load order, starting at index 0, and `sie_rd_last` is high while the final byte is shown.
- R5: An acknowledge after the data phase clears the byte count and the enable flag, and raises `cpu_tx_done_irq` for exactly one cycle.
- R6: A handshake timeout after the data phase keeps the bytes, the byte count and the enable flag, and raises no interrupt. The next IN token replays the packet from index 0.
- R7: A token flagged as corrupt (`sie_tok_bad` high with `sie_tok_valid`) produces neither a NAK nor a data pulse, and changes neither the enable flag nor the byte count.
- R8: A flush clears the byte count and the enable flag. If the flush arrives during a data phase, `sie_force_stuff_err` pulses high for one cycle in the next cycle; a flush outside a data phase gives no pulse.
- R9: After reset the enable flag is clear, the byte count is 0, and no pulse output is high.
- R10: With the enable flag set and a byte count of 0, an IN token still gives a `sie_send_data` pulse (a zero-length packet), and the block waits for the handshake at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_en | input | 1 | Processor byte write strobe |
| cpu_wr_data | input | DW | Byte to load |
| cpu_arm | input | 1 | Sets the enable flag (packet ready) |
| cpu_flush | input | 1 | Empties the buffer and clears the enable flag |
| cpu_armed | output | 1 | Enable flag |
| cpu_byte_count | output | $clog2(DEPTH+1) | Number of bytes loaded |
| cpu_tx_done_irq | output | 1 | One-cycle transmit-complete pulse |
| sie_tok_valid | input | 1 | IN token for this endpoint seen |
| sie_tok_bad | input | 1 | Token had a CRC, bit-stuff or PID error |
| sie_rd_req | input | 1 | Serializer consumes the shown byte |
| sie_rd_data | output | DW | Byte at the replay pointer |
| sie_rd_last | output | 1 | Shown byte is the last of the packet |
| sie_hs_ack | input | 1 | Host acknowledged the packet |
| sie_hs_timeout | input | 1 | No handshake arrived in time |
| sie_send_data | output | 1 | One-cycle pulse: start a data packet |
| sie_send_nak | output | 1 | One-cycle pulse: answer NAK |
| sie_force_stuff_err | output | 1 | One-cycle pulse: corrupt the packet on the wire |

## Verification
The data path is tried with a short packet that times out and is replayed, a packet loaded past the buffer size, a zero-length packet, and a packet cut off by a flush. The replay shows that the pointer returns to byte 0 and that the bytes survive a timeout. The overfilled packet shows that extra writes are dropped, not wrapped onto earlier bytes. Corrupt tokens, unarmed tokens and flushes both inside and outside a data phase separate the ignore, NAK and forced-error paths.

// File: rtl/in_ep_txbuf_pkg.sv
package in_ep_txbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } tx_state_e;
endpackage

// File: rtl/in_ep_txbuf_store.sv
module in_ep_txbuf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/in_ep_txbuf_ctrl.sv
module in_ep_txbuf_ctrl
    import in_ep_txbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr_en,
    input  logic          cpu_arm,
    input  logic          cpu_flush,
    input  logic          tok_valid,
    input  logic          tok_bad,
    input  logic          rd_req,
    input  logic          hs_ack,
    input  logic          hs_timeout,
    output logic          mem_we,
    output logic [PW-1:0] mem_waddr,
    output logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          armed,
    output logic          last,
    output logic          nak,
    output logic          start,
    output logic          irq,
    output logic          force_err
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        tx_state_e     st;
        logic          armed;
        logic [CW-1:0] count;
        logic [PW-1:0] rd_ptr;
        logic          nak;
        logic          start;
        logic          irq;
        logic          force_err;
    } ctrl_t;

    ctrl_t q, d;
    logic  good_tok;
    logic  at_last;

    assign good_tok = tok_valid && !tok_bad;
    assign at_last  = (q.st == ST_SEND) && (CW'(q.rd_ptr) == q.count - CW'(1));

    always_comb begin
        d           = q;
        d.nak       = 1'b0;
        d.start     = 1'b0;
        d.irq       = 1'b0;
        d.force_err = 1'b0;
        mem_we      = 1'b0;
        if (cpu_flush) begin
            d.st        = ST_IDLE;
            d.armed     = 1'b0;
            d.count     = '0;
            d.rd_ptr    = '0;
            d.force_err = (q.st == ST_SEND);
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (good_tok) begin
                        if (q.armed) begin
                            d.start  = 1'b1;
                            d.rd_ptr = '0;
                            d.st     = (q.count == '0) ? ST_WAIT : ST_SEND;
                        end else begin
                            d.nak = 1'b1;
                        end
                    end
                    if (!q.armed) begin
                        if (cpu_wr_en && (q.count < FULL)) begin
                            mem_we  = 1'b1;
                            d.count = q.count + CW'(1);
                        end
                        if (cpu_arm) d.armed = 1'b1;
                    end
                end
                ST_SEND: begin
                    if (rd_req) begin
                        d.rd_ptr = q.rd_ptr + PW'(1);
                        if (at_last) d.st = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (hs_ack) begin
                        d.st     = ST_IDLE;
                        d.armed  = 1'b0;
                        d.count  = '0;
                        d.rd_ptr = '0;
                        d.irq    = 1'b1;
                    end else if (hs_timeout) begin
                        d.st     = ST_IDLE;
                        d.rd_ptr = '0;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, armed: 1'b0, count: '0, rd_ptr: '0,
                   nak: 1'b0, start: 1'b0, irq: 1'b0, force_err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign mem_waddr = q.count[PW-1:0];
    assign rd_ptr    = q.rd_ptr;
    assign count     = q.count;
    assign armed     = q.armed;
    assign last      = at_last;
    assign nak       = q.nak;
    assign start     = q.start;
    assign irq       = q.irq;
    assign force_err = q.force_err;

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= FULL);

    // R2
    armed_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.armed && !cpu_flush && q.st == ST_IDLE) |=> $stable(q.count));

    // R3
    single_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.nak, q.start}));

    // R5
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && hs_ack && !cpu_flush) |=> (q.irq && !q.armed && q.count == '0));

    // R6
    timeout_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && hs_timeout && !hs_ack && !cpu_flush)
            |=> (q.armed && !q.irq && $stable(q.count)));

    // R7
    bad_token_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_bad && !cpu_flush) |=> (!q.nak && !q.start));

    // R8
    flush_midpacket_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SEND && cpu_flush) |=> (q.force_err && q.count == '0 && !q.armed));
endmodule

// File: rtl/in_ep_txbuf.sv
module in_ep_txbuf #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr_en,
    input  logic [DW-1:0] cpu_wr_data,
    input  logic          cpu_arm,
    input  logic          cpu_flush,
    output logic          cpu_armed,
    output logic [CW-1:0] cpu_byte_count,
    output logic          cpu_tx_done_irq,
    input  logic          sie_tok_valid,
    input  logic          sie_tok_bad,
    input  logic          sie_rd_req,
    output logic [DW-1:0] sie_rd_data,
    output logic          sie_rd_last,
    input  logic          sie_hs_ack,
    input  logic          sie_hs_timeout,
    output logic          sie_send_data,
    output logic          sie_send_nak,
    output logic          sie_force_stuff_err
);
    logic          mem_we;
    logic [PW-1:0] mem_waddr;
    logic [PW-1:0] rd_ptr;

    in_ep_txbuf_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_wr_en  (cpu_wr_en),
        .cpu_arm    (cpu_arm),
        .cpu_flush  (cpu_flush),
        .tok_valid  (sie_tok_valid),
        .tok_bad    (sie_tok_bad),
        .rd_req     (sie_rd_req),
        .hs_ack     (sie_hs_ack),
        .hs_timeout (sie_hs_timeout),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .rd_ptr     (rd_ptr),
        .count      (cpu_byte_count),
        .armed      (cpu_armed),
        .last       (sie_rd_last),
        .nak        (sie_send_nak),
        .start      (sie_send_data),
        .irq        (cpu_tx_done_irq),
        .force_err  (sie_force_stuff_err)
    );

    in_ep_txbuf_store #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) store_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (cpu_wr_data),
        .raddr (rd_ptr),
        .rdata (sie_rd_data)
    );
endmodule

// File: tb/in_ep_txbuf_tb_top.sv
module in_ep_txbuf_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int DW         = 8;
    localparam int CW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_wr_en = 1'b0;
    logic [DW-1:0] cpu_wr_data = '0;
    logic          cpu_arm = 1'b0;
    logic          cpu_flush = 1'b0;
    logic          cpu_armed;
    logic [CW-1:0] cpu_byte_count;
    logic          cpu_tx_done_irq;
    logic          sie_tok_valid = 1'b0;
    logic          sie_tok_bad = 1'b0;
    logic          sie_rd_req = 1'b0;
    logic [DW-1:0] sie_rd_data;
    logic          sie_rd_last;
    logic          sie_hs_ack = 1'b0;
    logic          sie_hs_timeout = 1'b0;
    logic          sie_send_data;
    logic          sie_send_nak;
    logic          sie_force_stuff_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [DW-1:0] model [DEPTH];
    int            model_cnt = 0;
    logic [DW-1:0] exp_q [$];
    bit            exp_last_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    in_ep_txbuf #(.DEPTH(DEPTH), .DW(DW)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard whenever the serializer consumes a byte
    always @(negedge clk) begin
        if (rst_n && sie_rd_req) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected read", 0, 1);
            end else begin
                logic [DW-1:0] e;
                bit            el;
                e  = exp_q.pop_front();
                el = exp_last_q.pop_front();
                chk(sie_rd_data == e, "R4 data byte", int'(sie_rd_data), int'(e));
                chk(sie_rd_last == el, "R4 last flag", int'(sie_rd_last), int'(el));
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [DW-1:0] b);
        cpu_wr_en   = 1'b1;
        cpu_wr_data = b;
        if (model_cnt < DEPTH && !cpu_armed) begin
            model[model_cnt] = b;
            model_cnt++;
        end
        cyc();
        cpu_wr_en = 1'b0;
    endtask

    task automatic token(input bit bad);
        sie_tok_valid = 1'b1;
        sie_tok_bad   = bad;
        cyc();
        sie_tok_valid = 1'b0;
        sie_tok_bad   = 1'b0;
    endtask

    // Driver: pushes expected bytes, then requests them
    task automatic read_bytes(input int total, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(model[i]);
            exp_last_q.push_back(i == total - 1);
            sie_rd_req = 1'b1;
            cyc();
        end
        sie_rd_req = 1'b0;
    endtask

    task automatic pulse_ack();
        sie_hs_ack = 1'b1;
        cyc();
        sie_hs_ack = 1'b0;
    endtask

    task automatic pulse_timeout();
        sie_hs_timeout = 1'b1;
        cyc();
        sie_hs_timeout = 1'b0;
    endtask

    task automatic arm();
        cpu_arm = 1'b1;
        cyc();
        cpu_arm = 1'b0;
    endtask

    task automatic flush();
        cpu_flush = 1'b1;
        cyc();
        cpu_flush = 1'b0;
        model_cnt = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R9 reset state
        chk(cpu_armed == 1'b0, "R9 armed", int'(cpu_armed), 0);
        chk(cpu_byte_count == '0, "R9 count", int'(cpu_byte_count), 0);
        chk({cpu_tx_done_irq, sie_send_data, sie_send_nak, sie_force_stuff_err} == 4'b0,
            "R9 pulses", int'({cpu_tx_done_irq, sie_send_data, sie_send_nak, sie_force_stuff_err}), 0);

        // R1 load five bytes
        for (int i = 0; i < 5; i++) wr(DW'(8'h30 + i * 7));
        chk(cpu_byte_count == CW'(5), "R1 count after load", int'(cpu_byte_count), 5);

        // R3 token while not enabled
        token(1'b0);
        chk(sie_send_nak == 1'b1, "R3 nak pulse", int'(sie_send_nak), 1);
        chk(sie_send_data == 1'b0, "R3 no data", int'(sie_send_data), 0);
        cyc();
        chk(sie_send_nak == 1'b0, "R3 nak one cycle", int'(sie_send_nak), 0);

        // R4 armed token and data phase
        arm();
        chk(cpu_armed == 1'b1, "R4 armed", int'(cpu_armed), 1);
        token(1'b0);
        chk(sie_send_data == 1'b1, "R4 data pulse", int'(sie_send_data), 1);
        chk(sie_send_nak == 1'b0, "R4 no nak", int'(sie_send_nak), 0);
        read_bytes(5, 5);

        // R6 timeout keeps the packet
        pulse_timeout();
        chk(cpu_armed == 1'b1, "R6 armed kept", int'(cpu_armed), 1);
        chk(cpu_tx_done_irq == 1'b0, "R6 no irq", int'(cpu_tx_done_irq), 0);
        chk(cpu_byte_count == CW'(5), "R6 count kept", int'(cpu_byte_count), 5);
        token(1'b0);
        chk(sie_send_data == 1'b1, "R6 replay start", int'(sie_send_data), 1);
        read_bytes(5, 5);
        pulse_timeout();

        // R7 corrupt token ignored
        token(1'b1);
        chk(sie_send_nak == 1'b0 && sie_send_data == 1'b0, "R7 no reply",
            int'({sie_send_nak, sie_send_data}), 0);
        chk(cpu_armed == 1'b1, "R7 armed kept", int'(cpu_armed), 1);
        chk(cpu_byte_count == CW'(5), "R7 count kept", int'(cpu_byte_count), 5);

        // R5 ack releases the packet
        token(1'b0);
        read_bytes(5, 5);
        pulse_ack();
        chk(cpu_tx_done_irq == 1'b1, "R5 irq", int'(cpu_tx_done_irq), 1);
        chk(cpu_armed == 1'b0, "R5 armed cleared", int'(cpu_armed), 0);
        chk(cpu_byte_count == '0, "R5 count cleared", int'(cpu_byte_count), 0);
        model_cnt = 0;
        cyc();
        chk(cpu_tx_done_irq == 1'b0, "R5 irq one cycle", int'(cpu_tx_done_irq), 0);

        // R1 overfill: extra writes dropped
        for (int i = 0; i < DEPTH + 3; i++) wr(DW'(8'h81 + i * 3));
        chk(cpu_byte_count == CW'(DEPTH), "R1 saturated", int'(cpu_byte_count), DEPTH);

        // R2 writes while enabled ignored
        arm();
        wr(8'hEE);
        chk(cpu_byte_count == CW'(DEPTH), "R2 count unchanged", int'(cpu_byte_count), DEPTH);
        token(1'b0);
        read_bytes(DEPTH, DEPTH);
        pulse_ack();
        model_cnt = 0;

        // R10 zero-length packet
        arm();
        token(1'b0);
        chk(sie_send_data == 1'b1, "R10 zlp start", int'(sie_send_data), 1);
        pulse_ack();
        chk(cpu_tx_done_irq == 1'b1, "R10 zlp irq", int'(cpu_tx_done_irq), 1);

        // R8 flush during data phase
        for (int i = 0; i < 4; i++) wr(DW'(8'h11 * (i + 1)));
        arm();
        token(1'b0);
        read_bytes(4, 2);
        flush();
        chk(sie_force_stuff_err == 1'b1, "R8 forced error", int'(sie_force_stuff_err), 1);
        chk(cpu_byte_count == '0, "R8 count cleared", int'(cpu_byte_count), 0);
        chk(cpu_armed == 1'b0, "R8 armed cleared", int'(cpu_armed), 0);
        cyc();
        chk(sie_force_stuff_err == 1'b0, "R8 error one cycle", int'(sie_force_stuff_err), 0);

        // R8 flush while idle: no forced error
        wr(8'h5A);
        wr(8'hA5);
        flush();
        chk(sie_force_stuff_err == 1'b0, "R8 idle flush no error", int'(sie_force_stuff_err), 0);
        chk(cpu_byte_count == '0, "R8 idle flush count", int'(cpu_byte_count), 0);

        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        cyc();
        finish_run();
    end
endmodule